// File: doc/BRIEF.md
# Translation Cache with Selective Invalidation

This block caches address translations for a four-level, 48-bit linear address space. It has two parts. A fully associative leaf TLB maps a 36-bit virtual page number to a 40-bit frame number and a page-size code. Three small caches hold upper-level paging-structure entries, one for each of levels 4, 3 and 2. A page walker outside the block loads entries through a single fill port. Lookups arrive with a virtual page number and return a hit flag, the frame and the page size one cycle later. Each lookup also returns a vector that shows which structure caches hold an entry on that address's path.

The block accepts four kinds of invalidation, and each kind removes a different set of entries. A page-fault invalidation prunes only what the faulting address would use. A single-address invalidate removes every fragment of a large page and empties the structure caches. An address-space switch keeps global leaf entries. A global-enable toggle removes everything. Each invalidation takes effect within one cycle and is answered by a done pulse.

Top module: `xlat_cache_inval`

## Requirements
- R1: After reset no entry is valid: every lookup misses with respPsc = 000, and invDone is low while no invalidation is requested.
- R2: A lookup (lkupValid) gives respValid one cycle later, together with hit, frame and size. A leaf entry whose size code is 00 (4 KB), 01 (2 MB) or 10 (1 GB) ignores the low 0, 9 or 18 page-number bits when it compares. An entry filled with fillFrag = 1 compares all 36 bits.
- R3: A page-fault invalidation (invKind 00) removes each leaf entry that a lookup of invVpn would hit. It also removes each structure-cache entry whose tag equals invVpn's bits on that level. Every other entry stays.
- R4: A single-address invalidate (invKind 01) removes in one request every leaf entry whose page, judged by its size code, covers invVpn, fragments included. It also clears all structure-cache entries. Leaf entries outside that page stay.
- R5: An address-space switch (invKind 10) removes every non-global leaf entry and all structure-cache entries. Global leaf entries stay.
- R6: A global-enable toggle (invKind 11) removes every leaf entry, global ones included, and every structure-cache entry.
- R7: invDone pulses high for exactly the cycle after each invalidation request, whether or not any entry matched.
- R8: A lookup in the same cycle as an invalidation returns the state that holds after the invalidation.
- R9: A fill presented in the same cycle as an invalidation is discarded.
- R10: A fill writes the lowest-index invalid slot. When every slot is valid, it writes the slot named by a round-robin pointer, which then advances. The pointer does not move when a free slot is used.
- R11: The level-4, level-3 and level-2 caches (fillKind 01, 10, 11; fillKind 00 loads the leaf TLB) are tagged with address bits 47:39, 47:30 and 47:21, which are page-number bits 35:27, 35:18 and 35:9. respPsc bit 2 reports level 4, bit 1 level 3 and bit 0 level 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkupValid | input | 1 | Lookup request |
| lkupVpn | input | 36 | Page number to look up (address bits 47:12) |
| fillValid | input | 1 | Fill request |
| fillKind | input | 2 | 00 leaf, 01 level 4, 10 level 3, 11 level 2 |
| fillVpn | input | 36 | Page number or structure tag source of the fill |
| fillSize | input | 2 | Page-size code of a leaf fill |
| fillFrag | input | 1 | Leaf fill is a 4 KB fragment of a larger page |
| fillGlobal | input | 1 | Leaf fill is global |
| fillFrame | input | 40 | Frame number of a leaf fill |
| invValid | input | 1 | Invalidation request |
| invKind | input | 2 | 00 fault, 01 single address, 10 space switch, 11 global toggle |
| invVpn | input | 36 | Page number of a fault or single-address invalidate |
| respValid | output | 1 | Lookup response valid |
| respHit | output | 1 | Leaf TLB hit |
| respFrame | output | 40 | Frame number on hit |
| respSize | output | 2 | Page-size code on hit |
| respPsc | output | 3 | Structure-cache hits, bit 2 level 4 to bit 0 level 2 |
| invDone | output | 1 | Invalidation completed |

## Verification
The bench aims at the differences between the invalidation kinds. A fault that flushed too much would lose a level-2 entry on an unrelated path, and a fault that flushed too little would leave a sibling path entry that should have been pruned. A single-address invalidate falling mid-page must remove fragments that do not hit that exact page number, so a design that used exact matching would leave them behind. The bench also puts a lookup, or a fill, in the same cycle as an invalidation; a design that ordered these wrongly would report a stale hit or keep a fill that should have been dropped. Finally, a free slot must be taken without moving the round-robin pointer, or a later eviction would remove the wrong page.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VPN_W = 36;
  localparam int PFN_W = 40;
  localparam int LVL_BITS = 9;
  localparam int PSC_LEVELS = 3;

  typedef enum logic [1:0] {
    INV_FAULT  = 2'b00,
    INV_PAGE   = 2'b01,
    INV_SWITCH = 2'b10,
    INV_TOGGLE = 2'b11
  } invKind_e;

  typedef enum logic [1:0] {
    FK_LEAF = 2'b00,
    FK_L4   = 2'b01,
    FK_L3   = 2'b10,
    FK_L2   = 2'b11
  } fillKind_e;

  typedef struct packed {
    logic                  leafFault;
    logic                  leafPage;
    logic                  leafLocal;
    logic                  leafAll;
    logic                  pscPath;
    logic                  pscAll;
    logic                  leafFill;
    logic [PSC_LEVELS-1:0] pscFill;
  } strobe_t;

  function automatic logic [VPN_W-1:0] sizeMask(input logic [1:0] sz);
    case (sz)
      2'b01:   return {{(VPN_W-LVL_BITS){1'b1}}, {LVL_BITS{1'b0}}};
      2'b10:   return {{(VPN_W-2*LVL_BITS){1'b1}}, {(2*LVL_BITS){1'b0}}};
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/xc_ctrl.sv
module xc_ctrl
  import xc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    invValid,
  input  logic [1:0] invKind,
  input  logic    fillValid,
  input  logic [1:0] fillKind,
  output strobe_t strb,
  output logic    invDone
);
  always_comb begin
    strb = '0;
    if (invValid) begin
      case (invKind_e'(invKind))
        INV_FAULT:  begin strb.leafFault = 1'b1; strb.pscPath = 1'b1; end
        INV_PAGE:   begin strb.leafPage  = 1'b1; strb.pscAll  = 1'b1; end
        INV_SWITCH: begin strb.leafLocal = 1'b1; strb.pscAll  = 1'b1; end
        default:    begin strb.leafAll   = 1'b1; strb.pscAll  = 1'b1; end
      endcase
    end else if (fillValid) begin
      case (fillKind_e'(fillKind))
        FK_LEAF: strb.leafFill   = 1'b1;
        FK_L4:   strb.pscFill[2] = 1'b1;
        FK_L3:   strb.pscFill[1] = 1'b1;
        default: strb.pscFill[0] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) invDone <= 1'b0;
    else       invDone <= invValid;
  end

  // R7
  done_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    invValid |=> invDone);
  // R7
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !invValid |=> !invDone);
endmodule

// File: rtl/xc_psc.sv
module xc_psc #(
  parameter int TAG_W = 9,
  parameter int N     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             killAll,
  input  logic             killPath,
  input  logic [TAG_W-1:0] pathTag,
  input  logic             fillEn,
  input  logic [TAG_W-1:0] fillTag,
  input  logic [TAG_W-1:0] lkTag,
  output logic             hitNow
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     val;
  logic [TAG_W-1:0] tags [N];
  logic [IDX_W-1:0] ptr, victim;
  logic [N-1:0]     killVec, lkVec;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      killVec[i] = killAll | (killPath & val[i] & (tags[i] == pathTag));
      lkVec[i]   = val[i] & (tags[i] == lkTag);
    end
    hitNow = |(lkVec & ~killVec);
    victim = ptr;
    for (int i = N - 1; i >= 0; i--) if (!val[i]) victim = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      val <= '0;
      ptr <= '0;
    end else begin
      val <= val & ~killVec;
      if (fillEn) begin
        val[victim]  <= 1'b1;
        tags[victim] <= fillTag;
        if (&val) ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  // R4 R5 R6
  psc_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    killAll |=> (val == '0));
endmodule

// File: rtl/xc_data.sv
module xc_data
  import xc_pkg::*;
#(
  parameter int TLB_N = 16,
  parameter int PSC_N = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [VPN_W-1:0]   invVpn,
  input  logic               lkupValid,
  input  logic [VPN_W-1:0]   lkupVpn,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [1:0]         fillSize,
  input  logic               fillFrag,
  input  logic               fillGlobal,
  input  logic [PFN_W-1:0]   fillFrame,
  output logic               respValid,
  output logic               respHit,
  output logic [PFN_W-1:0]   respFrame,
  output logic [1:0]         respSize,
  output logic [PSC_LEVELS-1:0] respPsc
);
  localparam int IDX_W = $clog2(TLB_N);

  logic [TLB_N-1:0] val, glb, frag;
  logic [VPN_W-1:0] vpn   [TLB_N];
  logic [1:0]       size  [TLB_N];
  logic [PFN_W-1:0] frame [TLB_N];
  logic [TLB_N-1:0] lkVec, faultVec, coverVec, killVec;
  logic [IDX_W-1:0] ptr, victim;
  logic [PSC_LEVELS-1:0] pscHitNow;
  logic             hitAny;
  logic [PFN_W-1:0] hitFrame;
  logic [1:0]       hitSize;

  for (genvar i = 0; i < TLB_N; i++) begin : g_match
    logic [VPN_W-1:0] exactMask;
    assign exactMask   = frag[i] ? '1 : sizeMask(size[i]);
    assign lkVec[i]    = val[i] & (((vpn[i] ^ lkupVpn) & exactMask) == '0);
    assign faultVec[i] = val[i] & (((vpn[i] ^ invVpn) & exactMask) == '0);
    assign coverVec[i] = val[i] & (((vpn[i] ^ invVpn) & sizeMask(size[i])) == '0);
    assign killVec[i]  = strb.leafAll | (strb.leafLocal & ~glb[i])
                       | (strb.leafFault & faultVec[i]) | (strb.leafPage & coverVec[i]);
  end

  always_comb begin
    hitAny   = 1'b0;
    hitFrame = '0;
    hitSize  = '0;
    for (int i = TLB_N - 1; i >= 0; i--) begin
      if (lkVec[i] && !killVec[i]) begin
        hitAny   = 1'b1;
        hitFrame = frame[i];
        hitSize  = size[i];
      end
    end
    victim = ptr;
    for (int i = TLB_N - 1; i >= 0; i--) if (!val[i]) victim = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      val <= '0;
      ptr <= '0;
    end else begin
      val <= val & ~killVec;
      if (strb.leafFill) begin
        val[victim]   <= 1'b1;
        glb[victim]   <= fillGlobal;
        frag[victim]  <= fillFrag;
        vpn[victim]   <= fillVpn;
        size[victim]  <= fillSize;
        frame[victim] <= fillFrame;
        if (&val) ptr <= (ptr == IDX_W'(TLB_N - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  for (genvar j = 0; j < PSC_LEVELS; j++) begin : g_psc
    localparam int TW = LVL_BITS * (PSC_LEVELS - j);
    xc_psc #(.TAG_W(TW), .N(PSC_N)) i_psc (
      .clk      (clk),
      .rstN     (rstN),
      .killAll  (strb.pscAll),
      .killPath (strb.pscPath),
      .pathTag  (invVpn[VPN_W-1 -: TW]),
      .fillEn   (strb.pscFill[j]),
      .fillTag  (fillVpn[VPN_W-1 -: TW]),
      .lkTag    (lkupVpn[VPN_W-1 -: TW]),
      .hitNow   (pscHitNow[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respFrame <= '0;
      respSize  <= '0;
      respPsc   <= '0;
    end else begin
      respValid <= lkupValid;
      respHit   <= lkupValid & hitAny;
      respFrame <= hitFrame;
      respSize  <= hitSize;
      respPsc   <= lkupValid ? pscHitNow : '0;
    end
  end

  // R6
  leaf_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.leafAll |=> (val == '0));
  // R5
  local_gone_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.leafLocal |=> ((val & ~glb) == '0));
  // R5
  global_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.leafLocal |=> ((val & glb) == $past(val & glb)));
  // R2
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);
endmodule

// File: rtl/xlat_cache_inval.sv
module xlat_cache_inval
  import xc_pkg::*;
#(
  parameter int TLB_N = 16,
  parameter int PSC_N = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lkupValid,
  input  logic [35:0] lkupVpn,
  input  logic        fillValid,
  input  logic [1:0]  fillKind,
  input  logic [35:0] fillVpn,
  input  logic [1:0]  fillSize,
  input  logic        fillFrag,
  input  logic        fillGlobal,
  input  logic [39:0] fillFrame,
  input  logic        invValid,
  input  logic [1:0]  invKind,
  input  logic [35:0] invVpn,
  output logic        respValid,
  output logic        respHit,
  output logic [39:0] respFrame,
  output logic [1:0]  respSize,
  output logic [2:0]  respPsc,
  output logic        invDone
);
  strobe_t strb;

  xc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .invValid(invValid), .invKind(invKind),
    .fillValid(fillValid), .fillKind(fillKind), .strb(strb), .invDone(invDone)
  );

  xc_data #(.TLB_N(TLB_N), .PSC_N(PSC_N)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .invVpn(invVpn),
    .lkupValid(lkupValid), .lkupVpn(lkupVpn),
    .fillVpn(fillVpn), .fillSize(fillSize), .fillFrag(fillFrag),
    .fillGlobal(fillGlobal), .fillFrame(fillFrame),
    .respValid(respValid), .respHit(respHit), .respFrame(respFrame),
    .respSize(respSize), .respPsc(respPsc)
  );
endmodule

// File: tb/test_xlat_cache_inval.sv
module test_xlat_cache_inval;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic lkupValid = 0, fillValid = 0, fillFrag = 0, fillGlobal = 0, invValid = 0;
  logic [35:0] lkupVpn = '0, fillVpn = '0, invVpn = '0;
  logic [1:0]  fillKind = '0, fillSize = '0, invKind = '0;
  logic [39:0] fillFrame = '0;
  logic respValid, respHit, invDone;
  logic [39:0] respFrame;
  logic [1:0]  respSize;
  logic [2:0]  respPsc;
  int total = 0, bad = 0;

  xlat_cache_inval i_xlat_cache_inval (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(logic [1:0] kind, logic [35:0] v, logic [1:0] sz,
                      logic fr, logic g, logic [39:0] f);
    @(negedge clk);
    fillValid = 1; fillKind = kind; fillVpn = v; fillSize = sz;
    fillFrag = fr; fillGlobal = g; fillFrame = f;
    @(negedge clk);
    fillValid = 0;
  endtask

  task automatic inval(logic [1:0] kind, logic [35:0] v);
    @(negedge clk);
    invValid = 1; invKind = kind; invVpn = v;
    @(negedge clk);
    invValid = 0;
    check("R7 done", invDone, 1);
    @(negedge clk);
    check("R7 single pulse", invDone, 0);
  endtask

  task automatic look(logic [35:0] v, string req, logic hit, logic [2:0] psc);
    @(negedge clk);
    lkupValid = 1; lkupVpn = v;
    @(negedge clk);
    lkupValid = 0;
    check({req, " valid"}, respValid, 1);
    check({req, " hit"}, respHit, hit);
    check({req, " psc"}, respPsc, psc);
  endtask

  task automatic t_reset();
    check("R1 done idle", invDone, 0);
    look(36'h0, "R1", 0, 3'b000);
    look(36'h1_2345_6789, "R1", 0, 3'b000);
  endtask

  task automatic t_basic();
    fill(2'b00, 36'h0_0000_1234, 2'b00, 0, 0, 40'hAA_0000_0001);
    look(36'h0_0000_1234, "R2 4k", 1, 3'b000);
    check("R2 frame", respFrame, 40'hAA_0000_0001);
    check("R2 size", respSize, 2'b00);
    look(36'h0_0000_1235, "R2 4k neighbour", 0, 3'b000);
    fill(2'b00, 36'h0_0020_0000, 2'b01, 0, 0, 40'hBB);
    look(36'h0_0020_01AB, "R2 2m", 1, 3'b000);
    check("R2 2m size", respSize, 2'b01);
    fill(2'b00, 36'h4_0000_0000, 2'b10, 0, 0, 40'hCC);
    look(36'h4_0002_1234, "R2 1g", 1, 3'b000);
    check("R2 1g size", respSize, 2'b10);
    look(36'h4_0004_0000, "R2 1g outside", 0, 3'b000);
    inval(2'b11, 36'h0);
  endtask

  task automatic t_fragments();
    fill(2'b00, 36'h0_1234_5600, 2'b01, 1, 0, 40'h1);
    fill(2'b00, 36'h0_1234_5603, 2'b01, 1, 0, 40'h2);
    fill(2'b00, 36'h0_1234_5607, 2'b01, 1, 0, 40'h3);
    fill(2'b00, 36'h0_1234_5800, 2'b00, 0, 0, 40'h4);
    fill(2'b11, 36'h0_1234_5600, 2'b00, 0, 0, 40'h0);
    look(36'h0_1234_5603, "R2 frag exact", 1, 3'b001);
    look(36'h0_1234_5604, "R2 frag other", 0, 3'b001);
    inval(2'b01, 36'h0_1234_5664);
    look(36'h0_1234_5600, "R4 frag0", 0, 3'b000);
    look(36'h0_1234_5603, "R4 frag3", 0, 3'b000);
    look(36'h0_1234_5607, "R4 frag7", 0, 3'b000);
    look(36'h0_1234_5800, "R4 outside kept", 1, 3'b000);
    inval(2'b01, 36'hF_FFFF_FFFF);
    look(36'h0_1234_5800, "R7 nomatch kept", 1, 3'b000);
    inval(2'b11, 36'h0);
  endtask

  task automatic t_fault();
    fill(2'b00, 36'h1_0000_0010, 2'b00, 0, 0, 40'h10);
    fill(2'b00, 36'h1_0000_0011, 2'b00, 0, 0, 40'h11);
    fill(2'b01, 36'h1_0000_0010, 2'b00, 0, 0, 40'h0);
    fill(2'b10, 36'h1_0000_0010, 2'b00, 0, 0, 40'h0);
    fill(2'b11, 36'h1_0000_0010, 2'b00, 0, 0, 40'h0);
    fill(2'b11, 36'h2_0000_0000, 2'b00, 0, 0, 40'h0);
    look(36'h1_0000_0010, "R11 path", 1, 3'b111);
    inval(2'b00, 36'h1_0000_0010);
    look(36'h1_0000_0010, "R3 faulted", 0, 3'b000);
    look(36'h1_0000_0011, "R3 sibling", 1, 3'b000);
    check("R3 sibling frame", respFrame, 40'h11);
    look(36'h2_0000_0000, "R3 other path", 0, 3'b001);
    inval(2'b11, 36'h0);
  endtask

  task automatic t_switch();
    fill(2'b00, 36'h3_0000_0000, 2'b00, 0, 1, 40'h30);
    fill(2'b00, 36'h3_0000_0001, 2'b00, 0, 0, 40'h31);
    fill(2'b10, 36'h3_0000_0000, 2'b00, 0, 0, 40'h0);
    look(36'h3_0000_0000, "R11 l3", 1, 3'b010);
    inval(2'b10, 36'h0);
    look(36'h3_0000_0000, "R5 global kept", 1, 3'b000);
    look(36'h3_0000_0001, "R5 local gone", 0, 3'b000);
    inval(2'b11, 36'h0);
    look(36'h3_0000_0000, "R6 global gone", 0, 3'b000);
  endtask

  task automatic t_same_cycle();
    fill(2'b00, 36'h5_0000_0000, 2'b00, 0, 0, 40'h50);
    @(negedge clk);
    invValid = 1; invKind = 2'b00; invVpn = 36'h5_0000_0000;
    lkupValid = 1; lkupVpn = 36'h5_0000_0000;
    @(negedge clk);
    invValid = 0; lkupValid = 0;
    check("R8 valid", respValid, 1);
    check("R8 post-inval miss", respHit, 0);
    check("R7 done with lookup", invDone, 1);
    @(negedge clk);
    fillValid = 1; fillKind = 2'b00; fillVpn = 36'h6_0000_0000; fillSize = 2'b00;
    fillFrag = 0; fillGlobal = 1; fillFrame = 40'h60;
    invValid = 1; invKind = 2'b11; invVpn = '0;
    @(negedge clk);
    fillValid = 0; invValid = 0;
    look(36'h6_0000_0000, "R9 fill dropped", 0, 3'b000);
  endtask

  task automatic t_replace();
    for (int i = 0; i < 16; i++)
      fill(2'b00, 36'h7_0000_0000 + 36'(i), 2'b00, 0, 0, 40'(i));
    fill(2'b00, 36'h8_0000_0000, 2'b00, 0, 0, 40'h80);
    look(36'h7_0000_0000, "R10 oldest evicted", 0, 3'b000);
    look(36'h7_0000_0001, "R10 next kept", 1, 3'b000);
    inval(2'b00, 36'h7_0000_0005);
    fill(2'b00, 36'h9_0000_0000, 2'b00, 0, 0, 40'h90);
    fill(2'b00, 36'hA_0000_0000, 2'b00, 0, 0, 40'hA0);
    look(36'h9_0000_0000, "R10 free slot used", 1, 3'b000);
    check("R10 frame", respFrame, 40'h90);
    look(36'h7_0000_0001, "R10 pointer victim", 0, 3'b000);
    look(36'h7_0000_0002, "R10 pointer not skipped", 1, 3'b000);
    look(36'hA_0000_0000, "R10 last fill", 1, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_basic();
    t_fragments();
    t_fault();
    t_switch();
    t_same_cycle();
    t_replace();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule